// File: doc/BRIEF.md
# Gated Power-of-Two Clock Divider

This block produces one or more divided clocks from a reference clock. Each channel divides the reference by a power of two. The ratio comes from a 3-bit logarithmic factor, where the factor gives a ratio of 2^(factor-1), and a factor of zero acts the same as a factor of one. Each channel also has an output gate that opens and closes without glitches. A byte-wide register port sets the factor and the enable bit for every channel. Each channel answers in its own address window, and the windows sit 256 bytes apart.

The enable bit is written in the bus clock domain. It passes through a two-flop synchronizer into the reference domain, where a small state machine starts or stops the divided clock. The output always opens and closes during a low phase, so no high pulse is ever cut short. Turn-on finishes within 2+3·div reference periods and turn-off within 3·div periods. The channel latches its factor while it is idle and holds it frozen while it runs. A factor written during a run therefore takes effect only at the next enable.

Top module: `clkdiv_bank`

## Requirements
- R1: Byte offset 0x43 of a channel window holds the divide factor in bits [2:0]. A read returns the last value written to those bits, and bits [7:3] read as zero.
- R2: Byte offset 0x46 of a channel window holds the enable in bit 7. A read returns the stored enable in bit 7, and bits [6:0] read as zero.
- R3: While a channel runs, its output has a ratio of 2^(f-1) reference periods for factor f = 1..7, and f = 0 behaves as f = 1. For ratios of 2 or more, the output is high for half the ratio and low for half. At a ratio of 1, the output is the gated reference clock.
- R4: The first high phase of the output begins within 2+3·div reference periods of the bus edge that sets the enable.
- R5: The output is low, and stays low, from 3·div reference periods after the bus edge that clears the enable.
- R6: Every high pulse of a divided output (ratio 2 or more) lasts exactly div/2 reference periods. This holds for the first pulse and the last one, and the output is held low while the channel is idle.
- R7: A factor written while a channel runs is stored and read back at once. The running ratio does not change, and the new factor applies after the next disable and enable.
- R8: Channel k answers at addresses k·0x100 + offset. A write to one channel leaves the registers and output of every other channel unchanged.
- R9: Offsets other than 0x43 and 0x46, and windows above the last channel, read as zero and ignore writes.
- R10: After reset, all factors and enables read as zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Register port clock |
| clk_ref | input | 1 | Reference clock that is divided |
| rst_n | input | 1 | Active-low synchronous reset, applied to both domains |
| wr_en | input | 1 | Write strobe, sampled on clk_bus |
| addr | input | ADDR_W | Byte address; bits [7:0] are the offset and the upper bits select the channel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| div_clk_o | output | N_CH | Gated divided clock, one bit per channel |

## Verification
The assertions assume three things about the inputs:
- The enable bit stays put long enough for each turn-on or turn-off to complete.
- Reset is held across edges of both clocks.
- The factor register is not changing at the edge where an idle channel starts. The factor crosses domains as a multi-bit value with no handshake.

The stimulus respects all three:
- It writes the factor before it sets the enable.
- It waits out the full latency window after every enable change before it touches the bit again.
- It runs both clock inputs from one 50 MHz source.

The only factor write made during a run is the R7 case. In that case the channel's latched copy is frozen, so the write cannot reach the divider.

// File: rtl/clkdiv_pkg.sv
// Shared constants, configuration type and ratio arithmetic for the
// gated power-of-two divider. Assumes a 3-bit logarithmic factor.
package clkdiv_pkg;

    localparam int FAC_W = 3;

    // Per-channel configuration as held in the register block.
    typedef struct packed {
        logic             en;
        logic [FAC_W-1:0] fac;
    } chan_cfg_t;

    // Division ratio for a factor; zero aliases to one.
    function automatic int unsigned ratio_of(input logic [FAC_W-1:0] f);
        int unsigned eff;
        eff = (f == '0) ? 1 : int'(f);
        return 32'd1 << (eff - 1);
    endfunction

    // Reference cycles spent in each half of the divided period.
    function automatic int unsigned half_of(input logic [FAC_W-1:0] f);
        return ratio_of(f) >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_sync.sv
// Two-flop synchronizer for a vector of level signals.
// Assumes each bit is quasi-static relative to the destination clock.
module clkdiv_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/clkdiv_regs.sv
// Register decode for all divider channels. Each channel owns a 256-byte
// window; only the factor and enable offsets are mapped. Reads are
// combinational on addr. Assumes ADDR_W > 8.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int         N_CH    = 3,
    parameter int         ADDR_W  = 10,
    parameter logic [7:0] OFF_FAC = 8'h43,
    parameter logic [7:0] OFF_EN  = 8'h46
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output chan_cfg_t [N_CH-1:0]  cfg_o
);

    localparam int CH_W = ADDR_W - 8;

    logic [CH_W-1:0] ch_idx;
    logic [7:0]      off;
    logic            unused_wbits;

    assign ch_idx       = addr[ADDR_W-1:8];
    assign off          = addr[7:0];
    assign unused_wbits = ^wdata[6:FAC_W];

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // Per-channel storage of factor and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[i] <= '0;
            end else if (wr_en && ch_idx == CH_W'(i)) begin
                if (off == OFF_FAC) cfg_o[i].fac <= wdata[FAC_W-1:0];
                if (off == OFF_EN)  cfg_o[i].en  <= wdata[7];
            end
        end
    end

    // Read mux: mapped fields only, everything else zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_idx == CH_W'(i)) begin
                if (off == OFF_FAC) rdata = {{(8-FAC_W){1'b0}}, cfg_o[i].fac};
                if (off == OFF_EN)  rdata = {cfg_o[i].en, 7'b0};
            end
        end
    end

endmodule

// File: rtl/clkdiv_chan.sv
// One divider channel in the reference domain. Starts and stops only
// while its output is low. Latches the factor while idle and freezes it
// while running. Ratio 1 passes the reference through a gate flop that
// changes on the falling edge. Assumes en_s is already synchronized.
module clkdiv_chan
    import clkdiv_pkg::*;
(
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic [FAC_W-1:0] fac_i,
    output logic             div_clk_o,
    output logic             run_o,
    output logic             sq_o,
    output logic [FAC_W-1:0] fac_o
);

    localparam logic [FAC_W-1:0] FAC_MAX  = '1;
    localparam int               MAX_HALF = int'(half_of(FAC_MAX));
    localparam int               CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    logic             run_q;
    logic             sq_q;
    logic             gate_q;
    logic [CNT_W-1:0] cnt_q;
    logic [FAC_W-1:0] fac_q;
    logic             is_div1;
    logic [CNT_W-1:0] half_m1;

    assign is_div1 = (ratio_of(fac_q) == 1);
    assign half_m1 = CNT_W'(half_of(fac_q) - 1);

    // Factor latch, open only while the channel is idle.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)      fac_q <= '0;
        else if (!run_q) fac_q <= fac_i;
    end

    // Run state, half-period counter and square wave.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            sq_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            sq_q  <= 1'b0;
            cnt_q <= '0;
            run_q <= en_s;
        end else if (!en_s && !sq_q) begin
            run_q <= 1'b0;
            sq_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!is_div1) begin
            if (cnt_q == half_m1) begin
                cnt_q <= '0;
                sq_q  <= ~sq_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Pass-through gate for ratio 1, updated while the reference is low.
    always_ff @(negedge clk_ref) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= en_s && is_div1;
    end

    assign div_clk_o = is_div1 ? (clk_ref & gate_q) : sq_q;
    assign run_o     = run_q;
    assign sq_o      = sq_q;
    assign fac_o     = fac_q;

endmodule

// File: rtl/clkdiv_bank.sv
// Top of the divider bank: register block in the bus domain, enable
// synchronizers and N_CH channels in the reference domain. Assumes rst_n
// is held across edges of both clocks.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int         N_CH    = 3,
    parameter int         ADDR_W  = 10,
    parameter logic [7:0] OFF_FAC = 8'h43,
    parameter logic [7:0] OFF_EN  = 8'h46
) (
    input  logic              clk_bus,
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [N_CH-1:0]   div_clk_o
);

    chan_cfg_t [N_CH-1:0]          cfg;
    logic [N_CH-1:0]               en_raw;
    logic [N_CH-1:0]               en_sync;
    logic [N_CH-1:0]               run_vec;
    logic [N_CH-1:0]               sq_vec;
    logic [N_CH-1:0][FAC_W-1:0]    fac_vec;

    clkdiv_regs #(
        .N_CH(N_CH), .ADDR_W(ADDR_W), .OFF_FAC(OFF_FAC), .OFF_EN(OFF_EN)
    ) u_regs (
        .clk(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cfg_o(cfg)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_en
        assign en_raw[i] = cfg[i].en;
    end

    clkdiv_sync #(.W(N_CH)) u_sync (
        .clk(clk_ref), .rst_n(rst_n), .d_i(en_raw), .q_o(en_sync)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        clkdiv_chan u_chan (
            .clk_ref(clk_ref), .rst_n(rst_n), .en_s(en_sync[i]),
            .fac_i(cfg[i].fac), .div_clk_o(div_clk_o[i]),
            .run_o(run_vec[i]), .sq_o(sq_vec[i]), .fac_o(fac_vec[i])
        );
    end

endmodule

// File: rtl/clkdiv_bank_chk.sv
// Assertion checker for clkdiv_bank, attached by bind. Watches register
// read data and the per-channel run state, square wave and latched factor.
module clkdiv_bank_chk
    import clkdiv_pkg::*;
#(
    parameter int         N_CH    = 3,
    parameter int         ADDR_W  = 10,
    parameter logic [7:0] OFF_FAC = 8'h43,
    parameter logic [7:0] OFF_EN  = 8'h46
) (
    input logic                       clk_bus,
    input logic                       clk_ref,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          addr,
    input logic [7:0]                 rdata,
    input logic [N_CH-1:0]            en_sync,
    input logic [N_CH-1:0]            run_vec,
    input logic [N_CH-1:0]            sq_vec,
    input logic [N_CH-1:0][FAC_W-1:0] fac_vec
);

    AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (addr[7:0] != OFF_FAC && addr[7:0] != OFF_EN) |-> rdata == 8'h00); // R9
    AST_RD_FAC_UPPER_ZERO: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (addr[7:0] == OFF_FAC) |-> rdata[7:FAC_W] == '0); // R1
    AST_RD_EN_LOWER_ZERO: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (addr[7:0] == OFF_EN) |-> rdata[6:0] == 7'h00); // R2

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        logic [7:0] hi_cnt;

        // Length of the current high phase of the square wave.
        always_ff @(posedge clk_ref) begin
            if (!rst_n)         hi_cnt <= '0;
            else if (sq_vec[i]) hi_cnt <= hi_cnt + 8'd1;
            else                hi_cnt <= '0;
        end

        AST_IDLE_HELD_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
            !run_vec[i] |-> !sq_vec[i]); // R6
        AST_PULSE_WIDTH: assert property (@(posedge clk_ref) disable iff (!rst_n)
            $fell(sq_vec[i]) |-> hi_cnt == 8'(half_of(fac_vec[i]))); // R6
        AST_FAC_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
            (run_vec[i] && $past(run_vec[i])) |-> $stable(fac_vec[i])); // R7
        AST_START_NEXT: assert property (@(posedge clk_ref) disable iff (!rst_n)
            (en_sync[i] && !run_vec[i]) |=> run_vec[i]); // R4
        AST_STOP_AT_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
            (!en_sync[i] && run_vec[i] && !sq_vec[i]) |=> !run_vec[i]); // R5
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .OFF_FAC(OFF_FAC), .OFF_EN(OFF_EN)
) u_chk (
    .clk_bus(clk_bus), .clk_ref(clk_ref), .rst_n(rst_n), .addr(addr),
    .rdata(rdata), .en_sync(en_sync), .run_vec(run_vec),
    .sq_vec(sq_vec), .fac_vec(fac_vec)
);

// File: tb/tb_clkdiv_bank.sv
// Self-checking bench: directed corner cases plus seeded random channel
// and factor choices. Both clocks come from one 50 MHz source.
module tb_clkdiv_bank;

    localparam int N_CH   = 3;
    localparam int ADDR_W = 10;
    localparam logic [7:0] FAC = 8'h43;
    localparam logic [7:0] ENR = 8'h46;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic [7:0]        rdata;
    logic [N_CH-1:0]   div_clk;

    clkdiv_bank #(.N_CH(N_CH), .ADDR_W(ADDR_W)) dut (
        .clk_bus(clk), .clk_ref(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .div_clk_o(div_clk)
    );

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=%0d expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bench_ratio(input int f);
        return (f == 0) ? 1 : (1 << (f - 1));
    endfunction

    function automatic logic [ADDR_W-1:0] a_of(input int c, input logic [7:0] off);
        return ADDR_W'(c * 256 + int'(off));
    endfunction

    task automatic bus_write(input int c, input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a_of(c, off); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input int c, input logic [7:0] off, output logic [7:0] d);
        @(negedge clk);
        addr = a_of(c, off);
        #1 d = rdata;
    endtask

    // Write the enable and find the first high sample within the bound.
    task automatic start_check(input int c, input int div, input string tag);
        int lim = 2 + 3 * div;
        int first = 0;
        bus_write(c, ENR, 8'h80);
        for (int k = 1; k <= lim; k++) begin
            @(posedge clk); #5;
            if (div_clk[c] && first == 0) first = k;
        end
        chk(first != 0, tag, first, lim);
    endtask

    // Align to a rising edge, then count ones and rises over 4 periods.
    task automatic measure(input int c, input int div, input string tag);
        int ones = 0;
        int rises = 0;
        int n = 4 * div;
        logic prev;
        logic s;
        if (div > 1) begin
            prev = 1'b1;
            for (int k = 0; k < 2 * div + 2; k++) begin
                @(posedge clk); #5;
                if (!prev && div_clk[c]) break;
                prev = div_clk[c];
            end
        end
        prev = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #5;
            s = div_clk[c];
            if (s) ones++;
            if (s && !prev) rises++;
            prev = s;
        end
        chk(ones == ((div == 1) ? n : n / 2), {tag, " ones"}, ones, (div == 1) ? n : n / 2);
        chk(rises == ((div == 1) ? 0 : 4), {tag, " rises"}, rises, (div == 1) ? 0 : 4);
        if (div == 1) begin
            #10;
            chk(div_clk[c] == 1'b0, {tag, " low phase"}, int'(div_clk[c]), 0);
        end
    endtask

    // Clear the enable, check whole pulses in the window, then silence.
    task automatic stop_check(input int c, input int div, input string tag);
        int hi = 0;
        int run = 0;
        bit seen0 = 0;
        bus_write(c, ENR, 8'h00);
        for (int k = 1; k <= 3 * div; k++) begin
            @(posedge clk); #5;
            if (div_clk[c]) run++;
            else begin
                if (seen0 && run > 0 && div > 1)
                    chk(run == div / 2, "R6 pulse width while stopping", run, div / 2);
                seen0 = 1; run = 0;
            end
        end
        for (int k = 0; k < 130; k++) begin
            @(posedge clk); #5;
            if (div_clk[c]) hi++;
            #10;
            if (div_clk[c]) hi++;
        end
        chk(hi == 0, tag, hi, 0);
    endtask

    task automatic run_channel(input int c, input int f);
        int div = bench_ratio(f);
        logic [7:0] d;
        bus_write(c, FAC, 8'(f));
        start_check(c, div, $sformatf("R4 start ch%0d f%0d", c, f));
        measure(c, div, $sformatf("R3 R6 ratio ch%0d f%0d", c, f));
        chk((div_clk & ~(N_CH'(1) << c)) == '0, "R8 other channels idle",
            int'(div_clk), int'(div_clk & (N_CH'(1) << c)));
        bus_read(c, ENR, d);
        chk(d == 8'h80, "R2 enable readback", d, 8'h80);
        stop_check(c, div, $sformatf("R5 stop ch%0d f%0d", c, f));
        bus_read(c, ENR, d);
        chk(d == 8'h00, "R2 enable cleared", d, 0);
    endtask

    initial begin
        logic [7:0] d;
        int lows;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state of registers and outputs.
        for (int c = 0; c < N_CH; c++) begin
            bus_read(c, FAC, d); chk(d == 0, "R10 factor after reset", d, 0);
            bus_read(c, ENR, d); chk(d == 0, "R10 enable after reset", d, 0);
        end
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #5; if (div_clk == '0) lows++;
            #10;                if (div_clk == '0) lows++;
        end
        chk(lows == 16, "R10 outputs low after reset", lows, 16);

        // R1: factor field width and readback.
        bus_write(0, FAC, 8'hFF); bus_read(0, FAC, d);
        chk(d == 8'h07, "R1 factor upper bits zero", d, 7);
        bus_write(0, FAC, 8'h05); bus_read(0, FAC, d);
        chk(d == 8'h05, "R1 factor readback", d, 5);

        // R2: bits other than 7 do not enable.
        bus_write(0, ENR, 8'h7F); bus_read(0, ENR, d);
        chk(d == 8'h00, "R2 only bit 7 stored", d, 0);

        // R9: unmapped offsets and windows.
        bus_write(0, 8'h44, 8'hFF); bus_read(0, 8'h44, d);
        chk(d == 0, "R9 unmapped offset reads zero", d, 0);
        bus_read(0, 8'h40, d);
        chk(d == 0, "R9 other offset reads zero", d, 0);
        bus_write(3, FAC, 8'h02); bus_read(3, FAC, d);
        chk(d == 0, "R9 window beyond channels reads zero", d, 0);
        bus_read(0, FAC, d);
        chk(d == 8'h05, "R9 stray writes ignored", d, 5);

        // R8: windows are independent.
        bus_write(1, FAC, 8'h02);
        bus_read(0, FAC, d); chk(d == 8'h05, "R8 ch0 untouched", d, 5);
        bus_read(2, FAC, d); chk(d == 8'h00, "R8 ch2 untouched", d, 0);
        bus_read(1, FAC, d); chk(d == 8'h02, "R8 ch1 written", d, 2);

        // R3: directed ratios including the zero alias and the maximum.
        run_channel(0, 0);
        run_channel(1, 1);
        run_channel(2, 7);
        run_channel(0, 2);

        // R7: factor rewritten during a run.
        bus_write(0, FAC, 8'h03);
        start_check(0, 4, "R7 start div4");
        measure(0, 4, "R7 before rewrite");
        bus_write(0, FAC, 8'h01);
        bus_read(0, FAC, d);
        chk(d == 8'h01, "R7 rewritten factor readback", d, 1);
        measure(0, 4, "R7 ratio unchanged during run");
        stop_check(0, 4, "R7 stop");
        start_check(0, 1, "R7 restart");
        measure(0, 1, "R7 new ratio after re-enable");
        stop_check(0, 1, "R7 stop after re-enable");

        // Random channels and factors.
        for (int it = 0; it < 8; it++) begin
            run_channel(int'($urandom_range(N_CH - 1, 0)), int'($urandom_range(7, 0)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule